// File: doc/BRIEF.md
# Interrupt vector ring writer

This block takes fixed-size interrupt vectors from clients and stores each into a circular buffer in memory. A vector is eight 32-bit words, and the block writes one word per cycle. Software sets up the ring through a small register bus: the base address, the ring size as a log2 of dwords, the enables, and the read pointer. The block owns the write pointer.

When the ring has no room, the block drops the incoming vector. It then sets a sticky overflow bit inside the write-pointer word. Software clears that bit by writing a 1 to a clear bit in the control register.

The block can store a copy of the write-pointer word to a programmable memory address after each vector event. It raises an interrupt while unread entries remain. Software can move the read pointer through a register write, or through a doorbell write when doorbell mode is on. Software disables the ring by clearing both enables and then writes zero to both pointers.

Top module: `intvec_ring_writer`

## Requirements
- R1: After reset, `vec_ready`, `irq` and `mem_we` are low. The control register (offset 0) and the write-pointer register (offset 5) read as 0.
- R2: An accepted vector is written as eight memory writes on eight consecutive cycles, starting in the cycle after the vector is accepted.
  - Write i goes to address `{BASE,8'h00} + wptr + 4*i` and carries `vec_data[32*i +: 32]`.
  - The BASE register (offset 1) holds address bits [39:8].
- R3: `vec_ready` is high only when the ring enable (CTRL bit 0) is set and the block is idle. It is low in the cycles in which a vector's words are being written.
- R4: The write pointer counts bytes. It advances by 32 for each vector that is stored and wraps modulo 2^(L+2), where L = CTRL[8:4] is log2 of the ring length in dwords (L is clamped to at least 3). Offset 5 reads the pointer with bit 0 holding the overflow flag.
- R5: A vector is dropped when the write pointer plus 32, wrapped, would equal the read pointer. A dropped vector causes no ring write and leaves the pointer unchanged, and it sets the overflow flag (bit 0 of the write-pointer word).
- R6: The overflow flag stays set through further vectors until a control write with bit 31 set clears it. Bit 31 is not stored.
- R7: When writeback is enabled (CTRL bit 2), each vector event is followed by one memory write of the write-pointer word, including the overflow flag.
  - The write goes to `{WBHI[7:0], WBLO[31:2], 2'b00}`, where WBLO is offset 2 and WBHI is offset 3.
  - It happens in the cycle after the last vector word, or in the cycle after acceptance for a dropped vector.
- R8: A register write to offset 4 sets the read pointer. A doorbell write sets it only when doorbell mode (CTRL bit 3) is set; otherwise the doorbell write is ignored.
- R9: `irq` is high exactly when the ring enable, the interrupt enable (CTRL bit 1) and an unequal write and read pointer all hold.
- R10: Registers read back what was written. A write to offset 5 sets the write pointer (bits [4:0] forced to zero), which is how software zeroes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be taken this cycle |
| vec_data | input | 256 | Eight vector words, word 0 in the low bits |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 40 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| db_we | input | 1 | Doorbell write strobe |
| db_wdata | input | 20 | Doorbell read-pointer value |
| irq | output | 1 | Unread entries remain |

## Verification
A write pointer that has stepped wrongly shows up on the address of the very next vector's first word. The monitor compares every memory write against its queue, so the error is reported one cycle after acceptance. A wrong full decision shows up as a ring write where none was queued, or as a missing one, within the same cycle window. A lost or stray overflow flag is visible at once through the write-pointer readback and, with writeback on, in the copied word. A sequencer that leaves its idle state wrongly holds `vec_ready` at a value the bench checks on the cycle after acceptance.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int unsigned WORDS_PER_VEC = 8;
  localparam int unsigned WORD_W        = 32;
  localparam int unsigned VEC_BYTES     = WORDS_PER_VEC * 4;
  localparam int unsigned ADDR_W        = 40;

  typedef enum logic [2:0] {
    RG_CTRL = 3'd0,
    RG_BASE = 3'd1,
    RG_WBLO = 3'd2,
    RG_WBHI = 3'd3,
    RG_RPTR = 3'd4,
    RG_WPTR = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_WRITE = 2'd1,
    SQ_WB    = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ivr_regs.sv
module ivr_regs
  import ivr_pkg::*;
#(
  parameter int unsigned PTR_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [2:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 db_we,
  input  logic [PTR_W-1:0]     db_wdata,
  input  logic [31:0]          wptr_word,
  output logic                 ring_en,
  output logic                 irq_en,
  output logic                 wb_en,
  output logic                 db_en,
  output logic [4:0]           size_l2,
  output logic [31:0]          base_hi,
  output logic [ADDR_W-1:0]    wb_addr,
  output logic [PTR_W-1:0]     rptr,
  output logic                 ovf_clr,
  output logic                 wptr_wr,
  output logic [PTR_W-1:0]     wptr_wval
);
  logic [29:0] wblo_q;
  logic [7:0]  wbhi_q;
  logic        sel_ctrl, sel_rptr;

  assign sel_ctrl  = reg_we && (reg_addr == RG_CTRL);
  assign sel_rptr  = reg_we && (reg_addr == RG_RPTR);
  assign ovf_clr   = sel_ctrl && reg_wdata[31];
  assign wptr_wr   = reg_we && (reg_addr == RG_WPTR);
  assign wptr_wval = {reg_wdata[PTR_W-1:5], 5'b00000};
  assign wb_addr   = {wbhi_q, wblo_q, 2'b00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_en <= 1'b0;
      irq_en  <= 1'b0;
      wb_en   <= 1'b0;
      db_en   <= 1'b0;
      size_l2 <= 5'd0;
      base_hi <= 32'd0;
      wblo_q  <= 30'd0;
      wbhi_q  <= 8'd0;
      rptr    <= '0;
    end else begin
      if (sel_ctrl) begin
        ring_en <= reg_wdata[0];
        irq_en  <= reg_wdata[1];
        wb_en   <= reg_wdata[2];
        db_en   <= reg_wdata[3];
        size_l2 <= reg_wdata[8:4];
      end
      if (reg_we && reg_addr == RG_BASE) base_hi <= reg_wdata;
      if (reg_we && reg_addr == RG_WBLO) wblo_q  <= reg_wdata[31:2];
      if (reg_we && reg_addr == RG_WBHI) wbhi_q  <= reg_wdata[7:0];
      if (sel_rptr)             rptr <= reg_wdata[PTR_W-1:0];
      else if (db_we && db_en)  rptr <= db_wdata;
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_addr)
      RG_CTRL: reg_rdata = {23'd0, size_l2, db_en, wb_en, irq_en, ring_en};
      RG_BASE: reg_rdata = base_hi;
      RG_WBLO: reg_rdata = {wblo_q, 2'b00};
      RG_WBHI: reg_rdata = {24'd0, wbhi_q};
      RG_RPTR: reg_rdata = {{(32-PTR_W){1'b0}}, rptr};
      RG_WPTR: reg_rdata = wptr_word;
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/ivr_ptr.sv
module ivr_ptr #(
  parameter int unsigned PTR_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PTR_W-1:0] mask,
  input  logic [PTR_W-1:0] rptr,
  input  logic             adv,
  input  logic             drop,
  input  logic             ovf_clr,
  input  logic             sw_wr,
  input  logic [PTR_W-1:0] sw_val,
  output logic [PTR_W-1:0] wptr,
  output logic             ovf,
  output logic             full
);
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [PTR_W-1:0] m);
    return (p + PTR_W'(32)) & m;
  endfunction

  assign full = (step_ptr(wptr, mask) == (rptr & mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (sw_wr)    wptr <= sw_val;
      else if (adv) wptr <= step_ptr(wptr, mask);
      if (drop)         ovf <= 1'b1;
      else if (ovf_clr) ovf <= 1'b0;
    end
  end
endmodule

// File: rtl/ivr_seq.sv
module ivr_seq
  import ivr_pkg::*;
#(
  parameter int unsigned PTR_W = 20,
  localparam int unsigned VEC_W = WORDS_PER_VEC * WORD_W,
  localparam int unsigned IDX_W = $clog2(WORDS_PER_VEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_en,
  input  logic              wb_en,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_data,
  output logic              vec_ready,
  input  logic              full,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [31:0]       base_hi,
  input  logic [ADDR_W-1:0] wb_addr,
  input  logic [31:0]       wptr_word,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  output logic              accept,
  output logic              adv,
  output logic              drop,
  output logic              busy
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS_PER_VEC - 1);

  seq_state_e state_q;
  logic [IDX_W-1:0] idx_q;
  logic [WORDS_PER_VEC-1:0][WORD_W-1:0] vec_q;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [31:0] b,
                                                  input logic [PTR_W-1:0] p,
                                                  input logic [IDX_W-1:0] i);
    return {b, 8'h00} + ADDR_W'(p) + ADDR_W'({i, 2'b00});
  endfunction

  assign busy      = (state_q != SQ_IDLE);
  assign vec_ready = ring_en && (state_q == SQ_IDLE);
  assign accept    = vec_valid && vec_ready;
  assign drop      = accept && full;
  assign adv       = (state_q == SQ_WRITE) && (idx_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      vec_q   <= '0;
    end else begin
      case (state_q)
        SQ_IDLE: if (accept) begin
          if (full) begin
            state_q <= wb_en ? SQ_WB : SQ_IDLE;
          end else begin
            vec_q   <= vec_data;
            idx_q   <= '0;
            state_q <= SQ_WRITE;
          end
        end
        SQ_WRITE: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST) state_q <= wb_en ? SQ_WB : SQ_IDLE;
        end
        SQ_WB:   state_q <= SQ_IDLE;
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    if (state_q == SQ_WRITE) begin
      mem_we    = 1'b1;
      mem_addr  = slot_addr(base_hi, wptr, idx_q);
      mem_wdata = vec_q[idx_q];
    end else if (state_q == SQ_WB) begin
      mem_we    = 1'b1;
      mem_addr  = wb_addr;
      mem_wdata = wptr_word;
    end
  end
endmodule

// File: rtl/intvec_ring_writer.sv
module intvec_ring_writer
  import ivr_pkg::*;
#(
  parameter int unsigned PTR_W = 20,
  localparam int unsigned VEC_W = WORDS_PER_VEC * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vec_valid,
  output logic              vec_ready,
  input  logic [VEC_W-1:0]  vec_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              db_we,
  input  logic [PTR_W-1:0]  db_wdata,
  output logic              irq
);
  function automatic logic [PTR_W-1:0] ring_mask(input logic [4:0] l2);
    int unsigned l;
    l = l2;
    if (l < 3) l = 3;
    if (l > PTR_W - 2) l = PTR_W - 2;
    return PTR_W'((64'd1 << (l + 2)) - 64'd1);
  endfunction

  logic ring_en, irq_en, wb_en, db_en;
  logic [4:0] size_l2;
  logic [31:0] base_hi;
  logic [ADDR_W-1:0] wb_addr;
  logic [PTR_W-1:0] rptr_q, wptr_q, ring_msk, wptr_sw_val;
  logic ovf_flag, ovf_clr_evt, wptr_sw_wr, full;
  logic accept, wptr_adv, drop_evt, busy;
  logic [31:0] wptr_word;

  assign ring_msk  = ring_mask(size_l2);
  assign wptr_word = {{(32-PTR_W){1'b0}}, wptr_q[PTR_W-1:1], ovf_flag};
  assign irq       = ring_en && irq_en && (wptr_q != (rptr_q & ring_msk));

  ivr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_we(db_we),
    .db_wdata(db_wdata), .wptr_word(wptr_word), .ring_en(ring_en),
    .irq_en(irq_en), .wb_en(wb_en), .db_en(db_en), .size_l2(size_l2),
    .base_hi(base_hi), .wb_addr(wb_addr), .rptr(rptr_q),
    .ovf_clr(ovf_clr_evt), .wptr_wr(wptr_sw_wr), .wptr_wval(wptr_sw_val)
  );

  ivr_ptr #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .mask(ring_msk), .rptr(rptr_q),
    .adv(wptr_adv), .drop(drop_evt), .ovf_clr(ovf_clr_evt),
    .sw_wr(wptr_sw_wr), .sw_val(wptr_sw_val), .wptr(wptr_q),
    .ovf(ovf_flag), .full(full)
  );

  ivr_seq #(.PTR_W(PTR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ring_en(ring_en), .wb_en(wb_en),
    .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
    .full(full), .wptr(wptr_q), .base_hi(base_hi), .wb_addr(wb_addr),
    .wptr_word(wptr_word), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .accept(accept), .adv(wptr_adv),
    .drop(drop_evt), .busy(busy)
  );
endmodule

// File: rtl/ivr_chk.sv
module ivr_chk #(
  parameter int unsigned PTR_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             vec_ready,
  input logic             accept,
  input logic             full,
  input logic             mem_we,
  input logic             drop_evt,
  input logic             ovf_flag,
  input logic             ovf_clr_evt,
  input logic             wptr_adv,
  input logic             wptr_sw_wr,
  input logic [PTR_W-1:0] wptr_q,
  input logic [PTR_W-1:0] ring_msk,
  input logic             ring_en,
  input logic             irq
);
  // R3
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !vec_ready);
  // R2
  store_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !full) |=> mem_we);
  // R5
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_flag);
  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && !wptr_sw_wr) |=> $stable(wptr_q));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr_evt) |=> ovf_flag);
  // R4
  wptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr_adv && !wptr_sw_wr) |=>
      (wptr_q == (($past(wptr_q) + PTR_W'(32)) & $past(ring_msk))));
  // R9
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_en |-> !irq);
endmodule

bind intvec_ring_writer ivr_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .vec_ready(vec_ready),
  .accept(accept), .full(full), .mem_we(mem_we), .drop_evt(drop_evt),
  .ovf_flag(ovf_flag), .ovf_clr_evt(ovf_clr_evt), .wptr_adv(wptr_adv),
  .wptr_sw_wr(wptr_sw_wr), .wptr_q(wptr_q), .ring_msk(ring_msk),
  .ring_en(ring_en), .irq(irq)
);

// File: tb/intvec_ring_writer_test.sv
module intvec_ring_writer_test;
  localparam int PTR_W = 20;
  localparam logic [39:0] RING_BASE = 40'h00_0012_0000;
  localparam logic [39:0] WB_ADR    = 40'h01_0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [255:0] vec_data = '0;
  logic mem_we;
  logic [39:0] mem_addr;
  logic [31:0] mem_wdata;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic db_we = 1'b0;
  logic [PTR_W-1:0] db_wdata = '0;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [71:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  intvec_ring_writer #(.PTR_W(PTR_W)) uut (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_data(vec_data), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_we(db_we),
    .db_wdata(db_wdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vword(input int seed, input int i);
    return 32'(seed) * 32'h0101_0101 + 32'(i) * 32'h10;
  endfunction

  function automatic logic [31:0] ctrl(input bit ring, input bit ie, input bit wb,
                                       input bit db, input int l2, input bit clr);
    return {clr, 22'd0, 5'(l2), db, wb, ie, ring};
  endfunction

  // monitor: every memory write must match the head of the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        chk("R2/R5 unexpected write", {mem_addr, mem_wdata}, 72'd0);
      end else begin
        logic [71:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic push_vec(input int seed, input logic [39:0] ptr);
    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({RING_BASE + ptr + 40'(4 * i), vword(seed, i)});
      tag_q.push_back("R2 ring word");
    end
  endtask

  task automatic push_wb(input logic [31:0] w);
    exp_q.push_back({WB_ADR, w});
    tag_q.push_back("R7 writeback");
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic db_wr(input logic [PTR_W-1:0] d);
    @(negedge clk);
    db_we = 1'b1; db_wdata = d;
    @(negedge clk);
    db_we = 1'b0;
  endtask

  task automatic send_vec(input int seed, input bit stored);
    @(negedge clk);
    chk("R3 ready before offer", 72'(vec_ready), 72'd1);
    for (int i = 0; i < 8; i++) vec_data[32*i +: 32] = vword(seed, i);
    vec_valid = 1'b1;
    @(negedge clk);
    vec_valid = 1'b0;
    if (stored) chk("R3 ready low while writing", 72'(vec_ready), 72'd0);
    repeat (11) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    chk("R1 ready", 72'(vec_ready), 72'd0);
    chk("R1 irq", 72'(irq), 72'd0);
    chk("R1 mem_we", 72'(mem_we), 72'd0);
    reg_rd(3'd5, rd); chk("R1 wptr", 72'(rd), 72'd0);
    reg_rd(3'd0, rd); chk("R1 ctrl", 72'(rd), 72'd0);

    reg_wr(3'd1, 32'h0000_1200);
    reg_wr(3'd0, ctrl(1, 1, 0, 0, 5, 0));
    @(negedge clk);
    chk("R3 ready when enabled", 72'(vec_ready), 72'd1);
    reg_rd(3'd0, rd); chk("R10 ctrl readback", 72'(rd), 72'h53);

    push_vec(1, 40'd0);
    send_vec(1, 1);
    reg_rd(3'd5, rd); chk("R4 wptr after one", 72'(rd), 72'd32);
    chk("R9 irq pending", 72'(irq), 72'd1);

    reg_wr(3'd4, 32'd32);
    #1;
    chk("R9 irq caught up", 72'(irq), 72'd0);
    reg_rd(3'd4, rd); chk("R8 rptr by register", 72'(rd), 72'd32);

    push_vec(2, 40'd32);  send_vec(2, 1);
    push_vec(3, 40'd64);  send_vec(3, 1);
    push_vec(4, 40'd96);  send_vec(4, 1);
    reg_rd(3'd5, rd); chk("R4 wrap to zero", 72'(rd), 72'd0);
    chk("R9 irq after wrap", 72'(irq), 72'd1);

    send_vec(5, 0);
    reg_rd(3'd5, rd); chk("R5 drop sets overflow, ptr held", 72'(rd), 72'd1);
    send_vec(6, 0);
    reg_rd(3'd5, rd); chk("R6 overflow sticky", 72'(rd), 72'd1);
    reg_wr(3'd0, ctrl(1, 1, 0, 0, 5, 1));
    reg_rd(3'd5, rd); chk("R6 overflow cleared", 72'(rd), 72'd0);
    reg_rd(3'd0, rd); chk("R6 clear bit not stored", 72'(rd), 72'h53);

    reg_wr(3'd2, 32'h0000_0400);
    reg_wr(3'd3, 32'h0000_0001);
    reg_wr(3'd4, 32'd0);
    reg_wr(3'd0, ctrl(1, 1, 1, 0, 5, 0));
    #1;
    chk("R9 irq empty ring", 72'(irq), 72'd0);
    push_vec(7, 40'd0);
    push_wb(32'd32);
    send_vec(7, 1);
    reg_rd(3'd5, rd); chk("R7 wptr after writeback", 72'(rd), 72'd32);

    reg_wr(3'd4, 32'd64);
    push_wb(32'd33);
    send_vec(8, 0);
    reg_rd(3'd5, rd); chk("R5 full drop with writeback", 72'(rd), 72'd33);
    reg_wr(3'd0, ctrl(1, 1, 1, 0, 5, 1));

    db_wr(20'd96);
    reg_rd(3'd4, rd); chk("R8 doorbell ignored when off", 72'(rd), 72'd64);
    chk("R9 irq with gap", 72'(irq), 72'd1);
    reg_wr(3'd0, ctrl(1, 1, 1, 1, 5, 0));
    db_wr(20'd32);
    reg_rd(3'd4, rd); chk("R8 doorbell sets rptr", 72'(rd), 72'd32);
    chk("R9 irq cleared by doorbell", 72'(irq), 72'd0);

    reg_wr(3'd0, ctrl(1, 0, 0, 1, 5, 0));
    reg_wr(3'd4, 32'd0);
    #1;
    chk("R9 irq masked by enable", 72'(irq), 72'd0);
    reg_wr(3'd0, 32'd0);
    #1;
    chk("R3 ready low when disabled", 72'(vec_ready), 72'd0);
    chk("R9 irq low when disabled", 72'(irq), 72'd0);

    reg_wr(3'd5, 32'd0);
    reg_rd(3'd5, rd); chk("R10 wptr zeroed", 72'(rd), 72'd0);
    reg_rd(3'd1, rd); chk("R10 base readback", 72'(rd), 72'h1200);
    reg_rd(3'd2, rd); chk("R10 wblo readback", 72'(rd), 72'h400);
    reg_rd(3'd3, rd); chk("R10 wbhi readback", 72'(rd), 72'h1);

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 72'(exp_q.size()), 72'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule